// File: doc/BRIEF.md
# Flash Array Program/Erase Model

This block is a synthesizable behavioural model of a small flash array with a command front end. A host issues one command at a time: read a page, program a page, erase a block, or retire a block by marking it bad. Programming can only pull bits from one to zero, because the stored word becomes the old contents ANDed with the new data. Erasing is the only way back to ones, and it works on a whole block of several pages at a time. Rewriting a page therefore needs an erase of its block first.

Each block has an erase counter and a bad flag. When the counter reaches a configurable endurance limit, the block is retired. A retired block, or a block the host has marked bad, refuses all further reads, programs and erases. Every command holds `busy` high for a fixed number of cycles that depends on the command type, with erase the longest and read the shortest. After that `done` pulses for one cycle, and the result is presented on `rdData` and `status`.

Top module: `flash_array_top`

## Requirements
- R1: After reset, `busy`, `done`, `rdData` and `status` are all zero, and every page reads back as all ones.
- R2: A command is taken when `cmdValid` is high and `busy` is low. `cmdOp` encodes the command: 00 is read, 01 is program, 10 is erase and 11 is mark-bad. `cmdAddr` is a page number, and its upper bits select the block. A program to a good block leaves the page holding the old value AND `cmdData`.
- R3: A program whose data has a 1 where the page holds a 0 completes with `status` 01 (program error). It still stores the ANDed value. Any other program to a good block returns `status` 00.
- R4: An erase of a good block sets every page of that block to all ones and leaves every other block untouched.
- R5: `busy` goes high in the cycle after acceptance and stays high for exactly READ_LAT cycles (read and mark-bad), PROG_LAT cycles (program) or ERASE_LAT cycles (erase). `done` is high for the single cycle after `busy` falls, and `busy` is low in that cycle.
- R6: `cmdValid` pulses while `busy` is high are ignored and change no page contents.
- R7: Each erase of a good block counts one cycle against it. The erase that brings the count to CYCLE_LIMIT succeeds, and the block is bad from then on. Read, program and erase commands to a bad block return `status` 10, return `rdData` zero and change nothing.
- R8: A mark-bad command marks its block bad and returns `status` 00. Other blocks keep working.
- R9: `rdData` carries the page contents for a successful read and zero for every other command. `rdData` and `status` only change in a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 2 | Command code (see R2) |
| cmdAddr | input | log2(NUM_BLKS)+log2(PAGES_PER_BLK) | Page number; upper bits give the block |
| cmdData | input | DATA_W | Program data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Read result |
| status | output | 2 | 00 ok, 01 program error, 10 bad block |

## Verification
The hardest state to reach from the ports is the endurance boundary. One block has to be erased exactly CYCLE_LIMIT times, and the bench checks that the last of those erases still succeeds and the next one is refused. A small limit is used for this, and erases to other blocks are mixed in so that the counters are shown to be per block. A second awkward case is a command presented during a long erase. The bench holds a destructive program request on the port for the whole busy window, then reads the targeted page to show that it was never taken. Program patterns are chosen per page so that second programs produce a mix of clean and error outcomes. The bench predicts each outcome from a bitwise AND model.

// File: rtl/flash_pkg.sv
package flash_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_MARK  = 2'b11
  } flashOp_e;

  typedef enum logic [1:0] {
    ST_OK       = 2'b00,
    ST_PROG_ERR = 2'b01,
    ST_BAD_BLK  = 2'b10,
    ST_RSVD     = 2'b11
  } flashSt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     fire;
    flashOp_e op;
  } ctrlStrobe_t;

endpackage

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_pkg::*;
#(
  parameter int READ_LAT  = 2,
  parameter int PROG_LAT  = 4,
  parameter int ERASE_LAT = 9,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              busy,
  output logic              done,
  output ctrlStrobe_t       strobe,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData
);

  localparam int MAX_LAT = (ERASE_LAT > PROG_LAT)
                         ? ((ERASE_LAT > READ_LAT) ? ERASE_LAT : READ_LAT)
                         : ((PROG_LAT > READ_LAT) ? PROG_LAT : READ_LAT);
  localparam int CNT_W = $clog2(MAX_LAT + 1);

  logic             busyQ;
  logic             doneQ;
  logic [CNT_W-1:0] cntQ;
  flashOp_e         opQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  function automatic logic [CNT_W-1:0] latFor(input logic [1:0] op);
    case (op)
      2'b01:   return CNT_W'(PROG_LAT - 1);
      2'b10:   return CNT_W'(ERASE_LAT - 1);
      default: return CNT_W'(READ_LAT - 1);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      cntQ  <= '0;
      opQ   <= OP_READ;
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ && cmdValid) begin
        busyQ <= 1'b1;
        opQ   <= flashOp_e'(cmdOp);
        addrQ <= cmdAddr;
        dataQ <= cmdData;
        cntQ  <= latFor(cmdOp);
      end else if (busyQ) begin
        if (cntQ == '0) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          cntQ <= cntQ - 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.fire = busyQ && (cntQ == '0);
    strobe.op   = opQ;
  end

  assign busy   = busyQ;
  assign done   = doneQ;
  assign opAddr = addrQ;
  assign opData = dataQ;

endmodule

// File: rtl/flash_datapath.sv
module flash_datapath
  import flash_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int NUM_BLKS      = 4,
  parameter int PAGES_PER_BLK = 4,
  parameter int CYCLE_LIMIT   = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctrlStrobe_t              strobe,
  input  logic [$clog2(NUM_BLKS)+$clog2(PAGES_PER_BLK)-1:0] opAddr,
  input  logic [DATA_W-1:0]        opData,
  output logic [DATA_W-1:0]        rdData,
  output logic [1:0]               status
);

  localparam int PAGE_W    = $clog2(PAGES_PER_BLK);
  localparam int BLK_W     = $clog2(NUM_BLKS);
  localparam int ADDR_W    = BLK_W + PAGE_W;
  localparam int NUM_PAGES = NUM_BLKS * PAGES_PER_BLK;
  localparam int WEAR_W    = $clog2(CYCLE_LIMIT + 1);

  logic [DATA_W-1:0] pageMem [NUM_PAGES];
  logic [BLK_W-1:0]  blkIdx;
  logic [DATA_W-1:0] curPage;
  logic [NUM_BLKS-1:0] badVec;
  logic [NUM_BLKS-1:0] eraseBlk;
  logic              blkBad;
  logic              progHit;
  logic              needsOne;

  assign blkIdx   = opAddr[ADDR_W-1:PAGE_W];
  assign curPage  = pageMem[opAddr];
  assign blkBad   = badVec[blkIdx];
  assign progHit  = strobe.fire && (strobe.op == OP_PROG) && !blkBad;
  assign needsOne = ((curPage & opData) != opData);

  // per-block wear counter and bad flag
  for (genvar b = 0; b < NUM_BLKS; b++) begin : g_blk
    logic              selHit;
    logic              markHit;
    logic              badQ;
    logic [WEAR_W-1:0] wearQ;

    assign selHit      = strobe.fire && (blkIdx == BLK_W'(b));
    assign markHit     = selHit && (strobe.op == OP_MARK);
    assign eraseBlk[b] = selHit && (strobe.op == OP_ERASE) && !badQ;
    assign badVec[b]   = badQ;

    always_ff @(posedge clk) begin
      if (rst) begin
        wearQ <= '0;
        badQ  <= 1'b0;
      end else begin
        if (eraseBlk[b]) begin
          wearQ <= wearQ + 1'b1;
          if (wearQ == WEAR_W'(CYCLE_LIMIT - 1)) badQ <= 1'b1;
        end
        if (markHit) badQ <= 1'b1;
      end
    end
  end

  // page storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PAGES; p++) pageMem[p] <= '1;
    end else begin
      for (int p = 0; p < NUM_PAGES; p++) begin
        if (eraseBlk[p / PAGES_PER_BLK]) begin
          pageMem[p] <= '1;
        end else if (progHit && (opAddr == ADDR_W'(p))) begin
          pageMem[p] <= pageMem[p] & opData;
        end
      end
    end
  end

  // result registers
  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
      status <= ST_OK;
    end else if (strobe.fire) begin
      if (strobe.op == OP_MARK) begin
        status <= ST_OK;
        rdData <= '0;
      end else if (blkBad) begin
        status <= ST_BAD_BLK;
        rdData <= '0;
      end else begin
        rdData <= (strobe.op == OP_READ) ? curPage : '0;
        status <= (strobe.op == OP_PROG && needsOne) ? ST_PROG_ERR : ST_OK;
      end
    end
  end

endmodule

// File: rtl/flash_array_top.sv
module flash_array_top
  import flash_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int NUM_BLKS      = 4,
  parameter int PAGES_PER_BLK = 4,
  parameter int CYCLE_LIMIT   = 3,
  parameter int READ_LAT      = 2,
  parameter int PROG_LAT      = 4,
  parameter int ERASE_LAT     = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [$clog2(NUM_BLKS)+$clog2(PAGES_PER_BLK)-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        status
);

  localparam int ADDR_W = $clog2(NUM_BLKS) + $clog2(PAGES_PER_BLK);

  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] opAddr;
  logic [DATA_W-1:0] opData;

  flash_ctrl #(
    .READ_LAT (READ_LAT),
    .PROG_LAT (PROG_LAT),
    .ERASE_LAT(ERASE_LAT),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cmdValid(cmdValid),
    .cmdOp   (cmdOp),
    .cmdAddr (cmdAddr),
    .cmdData (cmdData),
    .busy    (busy),
    .done    (done),
    .strobe  (strobe),
    .opAddr  (opAddr),
    .opData  (opData)
  );

  flash_datapath #(
    .DATA_W       (DATA_W),
    .NUM_BLKS     (NUM_BLKS),
    .PAGES_PER_BLK(PAGES_PER_BLK),
    .CYCLE_LIMIT  (CYCLE_LIMIT)
  ) i_dp (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .opAddr(opAddr),
    .opData(opData),
    .rdData(rdData),
    .status(status)
  );

endmodule

// File: rtl/flash_checker.sv
module flash_checker #(
  parameter int DATA_W    = 8,
  parameter int READ_LAT  = 2,
  parameter int PROG_LAT  = 4,
  parameter int ERASE_LAT = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              cmdValid,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rdData,
  input logic [1:0]        status
);

  logic [15:0] runLen;

  always_ff @(posedge clk) begin
    if (rst) runLen <= '0;
    else if (busy) runLen <= runLen + 1'b1;
    else runLen <= '0;
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && !busy) |=> busy);                                 // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                               // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);                                               // R5
  AST_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);                                         // R5
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (runLen == 16'(READ_LAT) || runLen == 16'(PROG_LAT)
                     || runLen == 16'(ERASE_LAT)));                // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(rdData) && $stable(status)));               // R9
  AST_BAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && status == 2'b10) |-> (rdData == '0));                 // R7
  AST_NO_RSVD: assert property (@(posedge clk) disable iff (rst)
    status != 2'b11);                                              // R3

endmodule

bind flash_array_top flash_checker #(
  .DATA_W   (DATA_W),
  .READ_LAT (READ_LAT),
  .PROG_LAT (PROG_LAT),
  .ERASE_LAT(ERASE_LAT)
) i_chk (
  .clk     (clk),
  .rst     (rst),
  .cmdValid(cmdValid),
  .busy    (busy),
  .done    (done),
  .rdData  (rdData),
  .status  (status)
);

// File: tb/test_flash_array_top.sv
module test_flash_array_top;

  localparam int DATA_W = 8;
  localparam int NB     = 4;
  localparam int PPB    = 4;
  localparam int NP     = NB * PPB;
  localparam int LIMIT  = 3;
  localparam int RL     = 2;
  localparam int PL     = 4;
  localparam int EL     = 9;

  logic       clk = 1'b0;
  logic       rst;
  logic       cmdValid;
  logic [1:0] cmdOp;
  logic [3:0] cmdAddr;
  logic [7:0] cmdData;
  logic       busy, done;
  logic [7:0] rdData;
  logic [1:0] status;

  int nChecks = 0;
  int nFails  = 0;

  logic [7:0] refMem [NP];
  bit         refBad [NB];
  int         refWear[NB];

  always #5 clk = ~clk;

  flash_array_top #(
    .DATA_W(DATA_W), .NUM_BLKS(NB), .PAGES_PER_BLK(PPB), .CYCLE_LIMIT(LIMIT),
    .READ_LAT(RL), .PROG_LAT(PL), .ERASE_LAT(EL)
  ) i_flash_array_top (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .busy(busy), .done(done), .rdData(rdData), .status(status)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // bench model: predicts result and updates reference state
  task automatic model(input int op, input int addr, input logic [7:0] data,
                       output int expRd, output int expSt, output int lat);
    int blk = addr / PPB;
    expRd = 0;
    expSt = 0;
    lat = (op == 1) ? PL : (op == 2) ? EL : RL;
    if (op == 3) begin
      refBad[blk] = 1'b1;
    end else if (refBad[blk]) begin
      expSt = 2;
    end else if (op == 0) begin
      expRd = refMem[addr];
    end else if (op == 1) begin
      expSt = ((refMem[addr] & data) != data) ? 1 : 0;
      refMem[addr] = refMem[addr] & data;
    end else begin
      for (int p = 0; p < PPB; p++) refMem[blk * PPB + p] = 8'hFF;
      refWear[blk]++;
      if (refWear[blk] >= LIMIT) refBad[blk] = 1'b1;
    end
  endtask

  // issue one command; optionally hold a program-to-zero request during busy
  task automatic run(input string tag, input int op, input int addr, input logic [7:0] data,
                     input bit noise = 1'b0, input int noiseAddr = 0);
    int expRd, expSt, lat, n;
    model(op, addr, data, expRd, expSt, lat);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdOp    = 2'(op);
    cmdAddr  = 4'(addr);
    cmdData  = data;
    @(negedge clk);
    if (noise) begin
      cmdOp   = 2'b01;
      cmdAddr = 4'(noiseAddr);
      cmdData = 8'h00;
    end else begin
      cmdValid = 1'b0;
    end
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    cmdValid = 1'b0;
    check("R5", "busy length", n, lat);
    check("R5", "done after busy", int'(done), 1);
    check(tag, "status", int'(status), expSt);
    check((op == 0) ? tag : "R9", "rdData", int'(rdData), expRd);
    @(negedge clk);
    check("R5", "done single cycle", int'(done), 0);
    check("R9", "rdData held", int'(rdData), expRd);
  endtask

  task automatic readAll(input string tag);
    for (int p = 0; p < NP; p++) run(tag, 0, p, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) refMem[p] = 8'hFF;
    for (int b = 0; b < NB; b++) begin
      refBad[b]  = 1'b0;
      refWear[b] = 0;
    end
    rst = 1'b1;
    cmdValid = 1'b0;
    cmdOp = 2'b00;
    cmdAddr = '0;
    cmdData = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "status", int'(status), 0);
    check("R1", "rdData", int'(rdData), 0);
    readAll("R1");

    // first program from erased state, then a second overlapping pattern
    for (int p = 0; p < NP; p++) run("R2", 1, p, 8'(p * 37 + 5));
    for (int p = 0; p < NP; p++) run("R3", 1, p, 8'(p * 91 + 3));
    run("R3", 1, 0, refMem[0]);  // subset of stored value: clean
    readAll("R2");

    // block erase of block 1
    run("R4", 2, 5, 8'h00);
    readAll("R4");

    // R6: held program request to page 6 during an erase of block 0
    run("R6", 2, 0, 8'h00, 1'b1, 6);
    run("R6", 0, 6, 8'h00);
    run("R6", 0, 1, 8'h00);

    // R7: wear block 2 out
    for (int i = 0; i < LIMIT; i++) run("R7", 2, 8 + i, 8'h00);
    run("R7", 2, 9, 8'h00);
    run("R7", 1, 10, 8'h0F);
    run("R7", 0, 10, 8'h00);
    run("R7", 0, 6, 8'h00);

    // R8: mark block 3 bad
    run("R8", 0, 13, 8'h00);
    run("R8", 3, 13, 8'h00);
    run("R8", 0, 14, 8'h00);
    run("R8", 1, 12, 8'h00);
    run("R8", 2, 15, 8'h00);
    run("R8", 3, 15, 8'h00);
    run("R8", 1, 4, 8'hA5);
    readAll("R8");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule